// File: doc/BRIEF.md
# Lockable Windowed Watchdog Timer

This block is a watchdog timer with a small register interface. A 12-bit down-counter is stepped by a slow tick strobe (one bus-clock-wide pulse, nominally at 256 Hz). A timeout of N seconds therefore needs a reload value of N*256-1, so timeouts of 1 to 16 seconds fit the field. Software keeps the system alive by writing a restart command that reloads the counter. The command counts only when it carries an 8-bit key.

Two events are faults. The first is the counter stepping below zero (underflow). The second is a restart that arrives while the counter is still above the configured window value (early restart). Each fault latches a status flag. The latched faults drive an interrupt line and a reset-request line, each gated by its own enable bit. Software may rewrite the mode register as often as it likes until it issues a keyed lock command. After the lock, the mode register is frozen until reset.

The counter can be paused by a debug or an idle input, each with its own enable bit. A disable bit stops the counter. While the disable bit is set, the reload and window fields are guarded against change.

Top module: `wdog_window`

Register map:
- Control register at 0x0. It is write-only and reads as zero.
- Mode register at 0x4.
- Status register at 0x8. It is read-only.

Mode register fields:

| Bits | Field |
|------|-------|
| [11:0] | Reload value |
| [12] | Interrupt enable |
| [13] | Reset-request enable |
| [14] | Core-only reset scope |
| [15] | Disable |
| [27:16] | Window value |
| [28] | Debug hold |
| [29] | Idle hold |
| [31:30] | Read as zero |

Status register fields:

| Bits | Field |
|------|-------|
| [0] | Underflow fault |
| [1] | Early-restart fault |
| [2] | Key error |
| [3] | Locked |
| [27:16] | Live counter value |

All other status bits read as zero.

## Requirements
- R1: After reset the counter, reload and window are all 0xFFF, and the mode register reads 0x0FFF_2FFF (reset-request enable set). Status reads 0x0FFF_0000 (not locked, no flags), and the irq, reset and scope outputs are low.
- R2: A tick pulse decrements the counter by one when the disable bit is 0 and no hold is active. The counter is visible in status [27:16].
- R3: A write to 0x0 with 0xA5 in bits [31:24] and bit 0 set reloads the counter from the reload field in the next cycle. The reload happens even while the block is disabled.
- R4: A write to 0x0 whose bits [31:24] are not 0xA5 has no effect on counter, mode or lock, and sets status bit 2.
- R5: A counted tick while the counter is 0 sets status bit 0 (underflow) and reloads the counter from the reload field.
- R6: A keyed restart while enabled and with the counter strictly greater than the window value sets status bit 1 (early restart). A restart with the counter equal to the window value does not.
- R7: Output irq_o is high when mode bit 12 is set and status bit 0 or 1 is set. Output rst_req_o is high under the same condition with mode bit 13. Output rst_core_o follows mode bit 14.
- R8: Reading 0x8 clears status bits 2:0 at that clock edge. A fault raised in the same cycle survives the clear.
- R9: The mode register takes any number of writes until a keyed write to 0x0 with bit 4 set. After that, status bit 3 is 1 and every mode write is ignored until reset.
- R10: While mode bit 15 is set, the counter does not move on ticks and no early fault is raised. Mode writes in that state leave bits [11:0] and [27:16] unchanged but update the other bits.
- R11: While bit 28 is set and dbg_i is high, ticks do not move the counter. The same holds for bit 29 with idle_i high.
- R12: A keyed restart and a tick in the same cycle resolve as a restart only. The counter takes the reload value and no underflow is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter tick strobe, one clock wide |
| dbg_i | input | 1 | System is in debug state |
| idle_i | input | 1 | System is in idle state |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Fault interrupt |
| rst_req_o | output | 1 | Fault reset request |
| rst_core_o | output | 1 | Reset request scope: core only |

## Verification
The bench targets the window boundary, where a restart at a counter exactly equal to the window value must pass. A strict-versus-loose comparison error would flag it or miss the case one above. It also lands a tick and a restart in the same cycle: a design with the wrong priority shows the decremented value or a stray underflow. A status read issued while a fault fires checks that the new flag is not lost. The bench further rewrites the mode register while disabled and after the lock. Here a missing guard shows up as a changed reload or window, or as a mode word that moves after locking. Long random runs with wrong keys, holds and reloads are compared against a bench model of the register behaviour.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 12;
  localparam int FLAG_W = 3;

  localparam logic [7:0] KEY_VAL = 8'hA5;
  localparam int KEY_LSB     = 24;
  localparam int CMD_RESTART = 0;
  localparam int CMD_LOCK    = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'h4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h8;

  // flag bit positions in the status word
  localparam int F_UNDER = 0;
  localparam int F_EARLY = 1;
  localparam int F_KEY   = 2;

  typedef struct packed {
    logic [1:0]       rsvd;
    logic             idle_hold;
    logic             dbg_hold;
    logic [CNT_W-1:0] window;
    logic             off;
    logic             core_only;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] reload;
  } mode_t;

  localparam mode_t MODE_RST = '{
    rsvd: 2'b00, idle_hold: 1'b0, dbg_hold: 1'b0,
    window: {CNT_W{1'b1}}, off: 1'b0, core_only: 1'b0,
    rst_en: 1'b1, irq_en: 1'b0, reload: {CNT_W{1'b1}}
  };
endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [FLAG_W-1:0] flags,
  output mode_t             mode_q,
  output logic              locked_q,
  output logic              restart_p,
  output logic              key_err_p,
  output logic              stat_rd_p,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int STAT_PAD_HI = DATA_W - 16 - CNT_W;
  localparam int STAT_PAD_LO = 16 - FLAG_W - 1;

  logic ctrl_wr, mode_wr, key_ok, lock_p;
  mode_t mode_in, mode_nx;

  assign ctrl_wr   = bus_en & bus_we & (bus_addr == A_CTRL);
  assign mode_wr   = bus_en & bus_we & (bus_addr == A_MODE);
  assign stat_rd_p = bus_en & ~bus_we & (bus_addr == A_STAT);
  assign key_ok    = bus_wdata[KEY_LSB +: 8] == KEY_VAL;
  assign restart_p = ctrl_wr & key_ok & bus_wdata[CMD_RESTART];
  assign lock_p    = ctrl_wr & key_ok & bus_wdata[CMD_LOCK];
  assign key_err_p = ctrl_wr & ~key_ok;

  always_comb begin
    mode_in      = mode_t'(bus_wdata);
    mode_in.rsvd = 2'b00;
    mode_nx      = mode_in;
    if (mode_q.off) begin
      mode_nx.reload = mode_q.reload;
      mode_nx.window = mode_q.window;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else begin
      if (mode_wr && !locked_q) mode_q <= mode_nx;
      if (lock_p) locked_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (bus_addr)
        A_MODE:  bus_rdata = mode_q;
        A_STAT:  bus_rdata = {{STAT_PAD_HI{1'b0}}, cnt, {STAT_PAD_LO{1'b0}}, locked_q, flags};
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             dbg_i,
  input  logic             idle_i,
  input  logic             restart_p,
  input  mode_t            mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             under_p,
  output logic             early_p
);
  logic halted, run;

  assign halted  = (mode.dbg_hold & dbg_i) | (mode.idle_hold & idle_i);
  assign run     = tick_i & ~mode.off & ~halted;
  // restart outranks any tick in the same cycle
  assign under_p = ~restart_p & run & (cnt_q == '0);
  assign early_p = restart_p & ~mode.off & (cnt_q > mode.window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '1;
    else if (restart_p)  cnt_q <= mode.reload;
    else if (run)        cnt_q <= (cnt_q == '0) ? mode.reload : cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              under_p,
  input  logic              early_p,
  input  logic              key_err_p,
  input  logic              stat_rd_p,
  input  logic              irq_en,
  input  logic              rst_en,
  output logic [FLAG_W-1:0] flags_q,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [FLAG_W-1:0] set_v;
  logic              fault;

  always_comb begin
    set_v          = '0;
    set_v[F_UNDER] = under_p;
    set_v[F_EARLY] = early_p;
    set_v[F_KEY]   = key_err_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (stat_rd_p ? '0 : flags_q) | set_v;
  end

  assign fault     = flags_q[F_UNDER] | flags_q[F_EARLY];
  assign irq_o     = irq_en & fault;
  assign rst_req_o = rst_en & fault;
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              dbg_i,
  input  logic              idle_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              rst_core_o
);
  mode_t             mode_q;
  logic              locked_q, restart_p, key_err_p, stat_rd_p;
  logic              under_p, early_p;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_W-1:0] flags_q;

  wdog_regif u_regif (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q), .flags(flags_q),
    .mode_q(mode_q), .locked_q(locked_q), .restart_p(restart_p),
    .key_err_p(key_err_p), .stat_rd_p(stat_rd_p), .bus_rdata(bus_rdata)
  );

  wdog_count u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_i(dbg_i), .idle_i(idle_i),
    .restart_p(restart_p), .mode(mode_q), .cnt_q(cnt_q),
    .under_p(under_p), .early_p(early_p)
  );

  wdog_fault u_fault (
    .clk(clk), .rst_n(rst_n), .under_p(under_p), .early_p(early_p),
    .key_err_p(key_err_p), .stat_rd_p(stat_rd_p), .irq_en(mode_q.irq_en),
    .rst_en(mode_q.rst_en), .flags_q(flags_q), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  assign rst_core_o = mode_q.core_only;
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_i,
  input logic        dbg_i,
  input logic        idle_i,
  input logic        bus_en,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] mode_q,
  input logic        locked_q,
  input logic [11:0] cnt_q
);
  logic rs, off, halt;
  assign rs   = bus_en & bus_we & (bus_addr == 4'h0) & (bus_wdata[31:24] == 8'hA5) & bus_wdata[0];
  assign off  = mode_q[15];
  assign halt = (mode_q[28] & dbg_i) | (mode_q[29] & idle_i);

  assert_reload_on_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> cnt_q == $past(mode_q[11:0]));
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !off && !halt && !rs && cnt_q != 12'd0) |=> cnt_q == $past(cnt_q) - 12'd1);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_q));
  assert_off_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !rs) |=> $stable(cnt_q));
  assert_field_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> $stable({mode_q[27:16], mode_q[11:0]}));
  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !rs) |=> $stable(cnt_q));
endmodule

bind wdog_window wdog_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_i(dbg_i), .idle_i(idle_i),
  .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .mode_q(mode_q), .locked_q(locked_q), .cnt_q(cnt_q)
);

// File: tb/tb_wdog_window.sv
module tb_wdog_window;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 0, dbg_i = 0, idle_i = 0, bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_o, rst_req_o, rst_core_o;
  int n_chk = 0, n_fail = 0;

  always #10ns clk = ~clk;

  wdog_window dut (.*);

  // reference state
  logic [31:0] m_mode = 32'h0FFF_2FFF;
  logic m_lock = 0;
  logic [11:0] m_cnt = 12'hFFF;
  logic [2:0] m_st = 0;

  function automatic logic [31:0] m_read(input logic [3:0] ad);
    if (ad == 4'h4) return m_mode;
    if (ad == 4'h8) return {4'h0, m_cnt, 12'h0, m_lock, m_st};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_step(input logic tk, dg, id, en, we, input logic [3:0] ad, input logic [31:0] wd);
    logic rs, lk, ena, run; logic [2:0] set;
    rs = 0; lk = 0; set = 0;
    if (en && we && ad == 4'h0) begin
      if (wd[31:24] == 8'hA5) begin rs = wd[0]; lk = wd[4]; end
      else set[2] = 1;
    end
    ena = !m_mode[15];
    run = tk && ena && !((m_mode[28] && dg) || (m_mode[29] && id));
    if (rs) begin
      if (ena && m_cnt > m_mode[27:16]) set[1] = 1;
      m_cnt = m_mode[11:0];
    end else if (run) begin
      if (m_cnt == 0) begin set[0] = 1; m_cnt = m_mode[11:0]; end
      else m_cnt = m_cnt - 1;
    end
    if (en && we && ad == 4'h4 && !m_lock) begin
      if (m_mode[15]) m_mode = {2'b0, wd[29:28], m_mode[27:16], wd[15:12], m_mode[11:0]};
      else            m_mode = {2'b0, wd[29:0]};
    end
    if (lk) m_lock = 1;
    m_st = ((en && !we && ad == 4'h8) ? 3'b0 : m_st) | set;
  endtask

  task automatic step(input logic tk, dg, id, en, we, input logic [3:0] ad,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    tick_i = tk; dbg_i = dg; idle_i = id; bus_en = en; bus_we = we; bus_addr = ad; bus_wdata = wd;
    #1;
    if (en && !we) chk(tag, bus_rdata, m_read(ad));
    @(posedge clk);
    m_step(tk, dg, id, en, we, ad, wd);
    #2;
    chk("R7 outputs", {29'b0, rst_core_o, rst_req_o, irq_o},
        {29'b0, m_mode[14], m_mode[13] & |m_st[1:0], m_mode[12] & |m_st[1:0]});
  endtask

  task automatic wr(input logic [3:0] ad, input logic [31:0] wd, input string tag);
    step(0, 0, 0, 1, 1, ad, wd, tag);
  endtask
  task automatic rd(input logic [3:0] ad, input string tag);
    step(0, 0, 0, 1, 0, ad, 0, tag);
  endtask
  task automatic ticks(input int n, input logic dg, input logic id);
    for (int i = 0; i < n; i++) step(1, dg, id, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 4'h8; #1;
    chk("R1 status", bus_rdata, 32'h0FFF_0000);
    bus_addr = 4'h4; #1;
    chk("R1 mode", bus_rdata, 32'h0FFF_2FFF);
    chk("R1 outputs", {29'b0, rst_core_o, rst_req_o, irq_o}, 32'h0);
    bus_en = 0;
    // R2 decrement
    ticks(3, 0, 0); rd(8, "R2 count");
    // R3 keyed restart
    wr(0, 32'hA500_0001, "R3"); rd(8, "R3 reload");
    // R4 wrong key
    wr(0, 32'h5A00_0011, "R4"); rd(8, "R4 key error"); rd(4, "R4 mode");
    rd(8, "R8 cleared");
    // R9 repeated mode writes
    wr(4, 32'h0003_3005, "R9"); rd(4, "R9 first write");
    wr(4, 32'h0003_3006, "R9"); rd(4, "R9 second write");
    wr(0, 32'hA500_0001, "R3"); wr(0, 32'hA500_0001, "R6 early");
    rd(8, "R6 early flag"); rd(8, "R8 clear");
    // R6 boundary: restart at counter == window
    ticks(3, 0, 0); wr(0, 32'hA500_0001, "R6"); rd(8, "R6 boundary");
    // R5 underflow
    ticks(7, 0, 0); rd(8, "R5 underflow"); rd(8, "R8 clear");
    // R8 read during fault: counter at 0, tick while reading
    ticks(6, 0, 0);
    step(1, 0, 0, 1, 0, 4'h8, 0, "R8 read with fault"); rd(8, "R8 fault kept");
    // R12 restart with tick
    ticks(4, 0, 0); step(1, 0, 0, 1, 1, 4'h0, 32'hA500_0001, "R12"); rd(8, "R12 restart wins");
    // R11 holds
    wr(4, 32'h1003_3006, "R11"); ticks(2, 1, 0); rd(8, "R11 debug hold");
    ticks(1, 0, 1); rd(8, "R11 idle unheld");
    wr(4, 32'h2003_3006, "R11"); ticks(2, 0, 1); rd(8, "R11 idle hold");
    // R10 disabled
    wr(4, 32'h0003_B006, "R10"); ticks(4, 0, 0); rd(8, "R10 frozen");
    wr(4, 32'h0007_C009, "R10"); rd(4, "R10 guarded fields");
    wr(0, 32'hA500_0001, "R10"); rd(8, "R10 no early");
    wr(4, 32'h0003_3006, "R10"); rd(4, "R10 re-enable");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [31:0] d = $urandom;
      logic dg = ($urandom_range(0, 3) == 0), id = ($urandom_range(0, 3) == 0);
      case (op)
        0, 1, 2, 3: step(1, dg, id, 0, 0, 0, 0, "R2 random");
        4: step($urandom_range(0, 1), dg, id, 1, 1, 4'h0,
                (($urandom_range(0, 3) != 0) ? {8'hA5, d[23:0]} : d) & 32'hFFFF_FFEF, "R3 random");
        5: step(0, dg, id, 1, 1, 4'h4, {d[31:16], d[15] & d[1], d[14:6], 6'h0} | {26'h0, d[5:0]}
                & 32'hF00F_FFFF, "R9 random");
        6, 7: step($urandom_range(0, 1), dg, id, 1, 0, 4'h8, 0, "R8 random status");
        default: step(1, dg, id, 1, 0, 4'h4, 0, "R9 random mode");
      endcase
    end
    // R9 lock
    wr(0, 32'hA500_0010, "R9 lock"); rd(8, "R9 locked flag");
    wr(4, 32'h0001_1001, "R9"); rd(4, "R9 frozen mode");
    wr(0, 32'hA500_0001, "R3"); rd(8, "R3 after lock");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule